// File: doc/BRIEF.md
# Byte-Addressed SMBus EEPROM Target

This block is a 256-byte EEPROM target that sits on a two-wire I2C/SMBus bus. It holds the bit-level target logic: line synchronisers, start and stop detection, device-address match, ACK generation and byte shifting. Behind that logic sit an 8-bit byte pointer and the storage array. The device answers at 7-bit address `0x50 | sel`, where `sel` is a 3-bit strap. Up to eight instances can therefore share one bus.

A write transaction carries a pointer byte and then any number of data bytes. The pointer byte always reloads the pointer. Each data byte is stored at the pointer, and the pointer then increments with wrap-around. A read transaction returns the byte at the pointer and increments it for every byte the controller takes. A pointer write followed by a repeated start with the read bit set gives a random read from the new pointer. Reset reloads the whole array from a parallel initial-image port, clears the pointer and clears an access indicator. Any read or write sets that indicator.

The controller FSM has seven states:
- `ST_IDLE`: wait for a start.
- `ST_ADDR`: shift in the address byte.
- `ST_ADDR_ACK`: drive the address ACK.
- `ST_WR_BYTE`: shift in a written byte.
- `ST_WR_ACK`: drive the data ACK.
- `ST_RD_BYTE`: shift out a read byte.
- `ST_RD_ACK`: sample the controller's ACK or NACK.

Its transitions are:
- Any state goes to `ST_ADDR` on a start, including a repeated start.
- Any state goes to `ST_IDLE` on a stop.
- `ST_ADDR` goes to `ST_ADDR_ACK` on an address match after eight bits. It goes to `ST_IDLE` on a mismatch.
- `ST_ADDR_ACK` goes to `ST_RD_BYTE` or `ST_WR_BYTE` at the falling SCL edge of the ACK clock, according to the R/W bit.
- `ST_WR_BYTE` goes to `ST_WR_ACK` after eight bits, and `ST_WR_ACK` goes back to `ST_WR_BYTE`.
- `ST_RD_BYTE` goes to `ST_RD_ACK` after eight bits.
- `ST_RD_ACK` goes to `ST_RD_BYTE` on an ACK and to `ST_IDLE` on a NACK.

Top module: `smbus_eeprom_tgt`

## Requirements
- R1: After reset the pointer is 0, so a plain read (address byte with R/W bit 1) returns initial-image byte 0. Byte i of the image is `init_image_i[8*i +: 8]`.
- R2: Only address byte `{0x50 | dev_sel_i, R/W}` is ACKed. A transfer to any other address gets no ACK at any bit. It also changes neither the pointer nor the array.
- R3: In a write (R/W bit 0), the first byte after the address loads the pointer.
- R4: Each further written byte is stored at the pointer, and the pointer then increments modulo 256 (0xFF wraps to 0x00).
- R5: Each byte a controller reads is the byte at the pointer. The pointer then increments modulo 256, so a read of address 0xFF is followed by address 0x00.
- R6: The target pulls SDA low during the ninth clock of its own address byte and of every written byte.
- R7: When the controller NACKs a read byte, the target releases SDA and drives nothing until the next start.
- R8: A pointer write, then a repeated start and a matching read address, reads from the new pointer.
- R9: `accessed_o` is 0 after reset. Any read or written byte sets it, and it stays 1 until reset.
- R10: Reset restores every byte from the initial image and discards all earlier writes.
- R11: Start is SDA falling while SCL is high, and stop is SDA rising while SCL is high. Both are sampled after a two-flop synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| dev_sel_i | input | 3 | Low bits of the 7-bit device address |
| init_image_i | input | 2048 | Reset contents, byte i at bits 8*i+7:8*i |
| accessed_o | output | 1 | Set by any read or written byte, cleared by reset |

## Verification
Writes are tried with several shapes:
- a multi-byte burst from a mid-array pointer, which separates the pointer-load byte from the stored bytes;
- a burst that starts at 0xFF, which shows whether the store wraps;
- a pointer-only write followed by a repeated start, which checks that the random read uses the new pointer.

Reads are tried in three forms:
- single plain reads, which show the pointer increment left by earlier transfers;
- multi-byte reads that cross 0xFF, which show the read wrap;
- a NACK-terminated read, after which the SDA level shows whether the target let go of the line.

Traffic to a wrong address and a reset after writes check what must not change: the pointer, the array, and the access flag.

// File: rtl/smbus_eeprom_pkg.sv
package smbus_eeprom_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK
    } tgt_state_e;

    localparam int unsigned BITS_PER_BYTE = 8;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_q,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_chain;
    logic [STAGES-1:0] sda_chain;
    logic              scl_prev;
    logic              sda_prev;
    logic              scl_q;

    // Synchroniser stages, built from a parameterised loop.
    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) begin
                        scl_chain[0] <= 1'b1;
                        sda_chain[0] <= 1'b1;
                    end else begin
                        scl_chain[0] <= scl_i;
                        sda_chain[0] <= sda_i;
                    end
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) begin
                        scl_chain[g] <= 1'b1;
                        sda_chain[g] <= 1'b1;
                    end else begin
                        scl_chain[g] <= scl_chain[g-1];
                        sda_chain[g] <= sda_chain[g-1];
                    end
                end
            end
        end
    endgenerate

    assign scl_q = scl_chain[STAGES-1];
    assign sda_q = sda_chain[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_q;
            sda_prev <= sda_q;
        end
    end

    assign scl_rise  =  scl_q & ~scl_prev;
    assign scl_fall  = ~scl_q &  scl_prev;
    assign start_det =  scl_q &  scl_prev & sda_prev & ~sda_q;
    assign stop_det  =  scl_q &  scl_prev & ~sda_prev & sda_q;

endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
    import smbus_eeprom_pkg::*;
#(
    parameter logic [6:0]  ADDR_BASE = 7'h50,
    parameter int unsigned SEL_W     = 3,
    parameter int unsigned DW        = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sda_q,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic [SEL_W-1:0] dev_sel,
    input  logic [DW-1:0]    rd_data,
    output logic             sda_oe,
    output logic             ptr_load,
    output logic             mem_we,
    output logic             ptr_inc,
    output logic [DW-1:0]    wr_byte,
    output tgt_state_e       state_o
);

    localparam int unsigned CNT_W = $clog2(BITS_PER_BYTE + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BITS_PER_BYTE);
    localparam logic [6:0] MY_ADDR_HI = ADDR_BASE;

    tgt_state_e       state_q, state_d;
    logic [CNT_W-1:0] bit_cnt;
    logic [DW-1:0]    rx_sh;
    logic [DW-1:0]    tx_sh;
    logic             first_wr;
    logic             mack_n;
    logic             addr_hit;
    logic             byte_end;
    logic             rd_load;
    logic             bus_evt;

    assign addr_hit = (rx_sh[DW-1:1] == {MY_ADDR_HI[6:SEL_W], dev_sel});
    assign byte_end = scl_fall && (bit_cnt == FULL);
    assign bus_evt  = start_det | stop_det;

    // State register.
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        if (start_det) begin
            state_d = ST_ADDR;
        end else if (stop_det) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_ADDR:     if (byte_end) state_d = addr_hit ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK: if (scl_fall) state_d = rx_sh[0] ? ST_RD_BYTE : ST_WR_BYTE;
                ST_WR_BYTE:  if (byte_end) state_d = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall) state_d = ST_WR_BYTE;
                ST_RD_BYTE:  if (byte_end) state_d = ST_RD_ACK;
                ST_RD_ACK:   if (scl_fall) state_d = mack_n ? ST_IDLE : ST_RD_BYTE;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // Outputs and strobes.
    always_comb begin
        sda_oe   = 1'b0;
        ptr_load = 1'b0;
        mem_we   = 1'b0;
        rd_load  = 1'b0;
        unique case (state_q)
            ST_ADDR_ACK: begin
                sda_oe  = 1'b1;
                rd_load = scl_fall & rx_sh[0] & ~bus_evt;
            end
            ST_WR_ACK:   sda_oe = 1'b1;
            ST_WR_BYTE: begin
                ptr_load = byte_end & first_wr  & ~bus_evt;
                mem_we   = byte_end & ~first_wr & ~bus_evt;
            end
            ST_RD_BYTE:  sda_oe  = ~tx_sh[DW-1];
            ST_RD_ACK:   rd_load = scl_fall & ~mack_n & ~bus_evt;
            default: ;
        endcase
        ptr_inc = mem_we | rd_load;
    end

    assign wr_byte = rx_sh;
    assign state_o = state_q;

    // Datapath registers.
    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt  <= '0;
            rx_sh    <= '0;
            tx_sh    <= '1;
            first_wr <= 1'b0;
            mack_n   <= 1'b1;
        end else begin
            if (start_det) begin
                bit_cnt <= '0;
            end else if (scl_fall && (state_q == ST_ADDR_ACK || state_q == ST_WR_ACK ||
                                      state_q == ST_RD_ACK)) begin
                bit_cnt <= '0;
            end else if (scl_rise && bit_cnt != FULL &&
                         (state_q == ST_ADDR || state_q == ST_WR_BYTE || state_q == ST_RD_BYTE)) begin
                bit_cnt <= bit_cnt + 1'b1;
            end

            if (scl_rise && bit_cnt != FULL && (state_q == ST_ADDR || state_q == ST_WR_BYTE))
                rx_sh <= {rx_sh[DW-2:0], sda_q};

            if (rd_load)
                tx_sh <= rd_data;
            else if (state_q == ST_RD_BYTE && scl_fall && bit_cnt != FULL)
                tx_sh <= {tx_sh[DW-2:0], 1'b1};
            else if (state_q != ST_RD_BYTE)
                tx_sh <= '1;

            if (state_q == ST_ADDR_ACK && scl_fall)
                first_wr <= ~rx_sh[0];
            else if (ptr_load || start_det)
                first_wr <= 1'b0;

            if (state_q == ST_RD_ACK && scl_rise)
                mack_n <= sda_q;
        end
    end

endmodule

// File: rtl/eeprom_store.sv
module eeprom_store #(
    parameter int unsigned DEPTH = 256,
    parameter int unsigned DW    = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [DEPTH*DW-1:0] init_image,
    input  logic                ptr_load,
    input  logic                mem_we,
    input  logic                ptr_inc,
    input  logic [DW-1:0]       wr_byte,
    output logic [DW-1:0]       rd_data,
    output logic [$clog2(DEPTH)-1:0] ptr_o,
    output logic                accessed
);

    localparam int unsigned AW = $clog2(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= init_image[i*DW +: DW];
        end else if (mem_we) begin
            mem[ptr_q] <= wr_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q    <= '0;
            accessed <= 1'b0;
        end else begin
            if (ptr_load)     ptr_q <= wr_byte[AW-1:0];
            else if (ptr_inc) ptr_q <= ptr_q + 1'b1;
            if (ptr_load || mem_we || ptr_inc) accessed <= 1'b1;
        end
    end

    assign rd_data = mem[ptr_q];
    assign ptr_o   = ptr_q;

endmodule

// File: rtl/smbus_eeprom_tgt.sv
module smbus_eeprom_tgt
    import smbus_eeprom_pkg::*;
#(
    parameter logic [6:0]  ADDR_BASE = 7'h50,
    parameter int unsigned SEL_W     = 3,
    parameter int unsigned DEPTH     = 256,
    parameter int unsigned DW        = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                scl_i,
    input  logic                sda_i,
    output logic                sda_oe_o,
    input  logic [SEL_W-1:0]    dev_sel_i,
    input  logic [DEPTH*DW-1:0] init_image_i,
    output logic                accessed_o
);

    localparam int unsigned AW = $clog2(DEPTH);

    logic          sda_q, scl_rise, scl_fall, start_det, stop_det;
    logic          ptr_load, mem_we, ptr_inc;
    logic [DW-1:0] wr_byte, rd_data;
    logic [AW-1:0] ptr_q;
    tgt_state_e    state_q;

    i2c_line_sync #(.STAGES(2)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_q     (sda_q),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_tgt_fsm #(.ADDR_BASE(ADDR_BASE), .SEL_W(SEL_W), .DW(DW)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .sda_q     (sda_q),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .dev_sel   (dev_sel_i),
        .rd_data   (rd_data),
        .sda_oe    (sda_oe_o),
        .ptr_load  (ptr_load),
        .mem_we    (mem_we),
        .ptr_inc   (ptr_inc),
        .wr_byte   (wr_byte),
        .state_o   (state_q)
    );

    eeprom_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk        (clk),
        .rst        (rst),
        .init_image (init_image_i),
        .ptr_load   (ptr_load),
        .mem_we     (mem_we),
        .ptr_inc    (ptr_inc),
        .wr_byte    (wr_byte),
        .rd_data    (rd_data),
        .ptr_o      (ptr_q),
        .accessed   (accessed_o)
    );

endmodule

// File: rtl/smbus_eeprom_chk.sv
module smbus_eeprom_chk #(
    parameter int unsigned AW = 8,
    parameter int unsigned DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          accessed,
    input logic          sda_oe,
    input logic          stop_det,
    input logic          ptr_load,
    input logic          ptr_inc,
    input logic [DW-1:0] wr_byte,
    input logic [AW-1:0] ptr
);

    // R1
    ptr_cleared_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ptr == '0));

    // R9
    accessed_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        accessed |=> accessed);

    // R3
    ptr_load_chk: assert property (@(posedge clk) disable iff (rst)
        ptr_load |=> (ptr == $past(wr_byte[AW-1:0])));

    // R5
    ptr_wrap_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (ptr_inc && !ptr_load) |=> (ptr == AW'($past(ptr) + 1'b1)));

    // R7
    release_on_stop_chk: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> !sda_oe);

endmodule

bind smbus_eeprom_tgt smbus_eeprom_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .accessed (accessed_o),
    .sda_oe   (sda_oe_o),
    .stop_det (stop_det),
    .ptr_load (ptr_load),
    .ptr_inc  (ptr_inc),
    .wr_byte  (wr_byte),
    .ptr      (ptr_q)
);

// File: tb/test_smbus_eeprom_tgt.sv
module test_smbus_eeprom_tgt;

    localparam int DEPTH = 256;
    localparam int Q = 10;
    localparam int H = 20;
    localparam logic [7:0] WADDR = 8'hA4;
    localparam logic [7:0] RADDR = 8'hA5;
    localparam logic [7:0] XADDR = 8'hA6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic tb_sda_low = 1'b0;
    logic sda_oe;
    logic sda_line;
    logic accessed;
    logic [DEPTH*8-1:0] image;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    assign sda_line = ~(tb_sda_low | sda_oe);

    function automatic logic [7:0] img(input int i);
        return 8'((i * 7 + 3) & 8'hFF);
    endfunction

    always_comb begin
        for (int i = 0; i < DEPTH; i++) image[i*8 +: 8] = img(i);
    end

    smbus_eeprom_tgt i_smbus_eeprom_tgt (
        .clk          (clk),
        .rst          (rst),
        .scl_i        (scl),
        .sda_i        (sda_line),
        .sda_oe_o     (sda_oe),
        .dev_sel_i    (3'b010),
        .init_image_i (image),
        .accessed_o   (accessed)
    );

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic i2c_start;
        tb_sda_low = 1'b0; cyc(Q);
        scl = 1'b1;        cyc(H);
        tb_sda_low = 1'b1; cyc(H);
        scl = 1'b0;        cyc(Q);
    endtask

    task automatic i2c_stop;
        tb_sda_low = 1'b1; cyc(Q);
        scl = 1'b1;        cyc(H);
        tb_sda_low = 1'b0; cyc(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            cyc(Q); tb_sda_low = ~b[i]; cyc(Q);
            scl = 1'b1; cyc(H); scl = 1'b0;
        end
        cyc(Q); tb_sda_low = 1'b0; cyc(Q);
        scl = 1'b1; cyc(H/2); ack = ~sda_line; cyc(H/2); scl = 1'b0;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        tb_sda_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            cyc(2*Q); scl = 1'b1; cyc(H/2); b[i] = sda_line; cyc(H/2); scl = 1'b0;
        end
        cyc(Q); tb_sda_low = give_ack; cyc(Q);
        scl = 1'b1; cyc(H); scl = 1'b0; cyc(Q);
        tb_sda_low = 1'b0;
    endtask

    task automatic read_one(input string req, input logic [7:0] exp);
        logic ack;
        logic [7:0] d;
        i2c_start;
        send_byte(RADDR, ack);
        check(ack, "R2 read address ACK", int'(ack), 1);
        recv_byte(1'b0, d);
        i2c_stop;
        check(d == exp, req, int'(d), int'(exp));
    endtask

    task automatic set_ptr_rs(input logic [7:0] p);
        logic ack;
        i2c_start;
        send_byte(WADDR, ack); check(ack, "R6 addr ACK", int'(ack), 1);
        send_byte(p, ack);     check(ack, "R6 pointer ACK", int'(ack), 1);
        i2c_start;
        send_byte(RADDR, ack); check(ack, "R8 repeated-start read ACK", int'(ack), 1);
    endtask

    task automatic t_reset_state;
        check(accessed == 1'b0, "R9 accessed clear after reset", int'(accessed), 0);
        check(sda_line == 1'b1, "R7 SDA idle after reset", int'(sda_line), 1);
        read_one("R1 first read is image byte 0", img(0));
        check(accessed == 1'b1, "R9 accessed set by read", int'(accessed), 1);
    endtask

    task automatic t_addr_mismatch;
        logic ack;
        i2c_start;
        send_byte(XADDR, ack); check(!ack, "R2 foreign address not ACKed", int'(ack), 0);
        send_byte(8'h80, ack); check(!ack, "R2 foreign data not ACKed", int'(ack), 0);
        send_byte(8'h5A, ack); check(!ack, "R2 foreign data not ACKed", int'(ack), 0);
        i2c_stop;
        read_one("R2 pointer unchanged by foreign traffic", img(1));
    endtask

    task automatic t_write_then_read;
        logic ack;
        logic [7:0] d;
        i2c_start;
        send_byte(WADDR, ack); check(ack, "R6 write addr ACK", int'(ack), 1);
        send_byte(8'h10, ack); check(ack, "R6 pointer byte ACK", int'(ack), 1);
        send_byte(8'h11, ack); check(ack, "R6 data ACK", int'(ack), 1);
        send_byte(8'h22, ack); check(ack, "R6 data ACK", int'(ack), 1);
        send_byte(8'h33, ack); check(ack, "R6 data ACK", int'(ack), 1);
        i2c_stop;
        read_one("R4 pointer advanced past burst", img(8'h13));
        set_ptr_rs(8'h10);
        recv_byte(1'b1, d); check(d == 8'h11, "R3 R8 first stored byte", int'(d), 'h11);
        recv_byte(1'b1, d); check(d == 8'h22, "R4 second stored byte", int'(d), 'h22);
        recv_byte(1'b0, d); check(d == 8'h33, "R4 third stored byte", int'(d), 'h33);
        i2c_stop;
    endtask

    task automatic t_wrap_write;
        logic ack;
        logic [7:0] d;
        i2c_start;
        send_byte(WADDR, ack);
        send_byte(8'hFF, ack);
        send_byte(8'hD1, ack); check(ack, "R6 data ACK at 0xFF", int'(ack), 1);
        send_byte(8'hE2, ack); check(ack, "R6 data ACK after wrap", int'(ack), 1);
        i2c_stop;
        set_ptr_rs(8'hFF);
        recv_byte(1'b1, d); check(d == 8'hD1, "R4 byte stored at 0xFF", int'(d), 'hD1);
        recv_byte(1'b0, d); check(d == 8'hE2, "R4 write wrapped to 0x00", int'(d), 'hE2);
        i2c_stop;
        read_one("R5 read pointer wrapped to 0x01", img(1));
    endtask

    task automatic t_nack_release;
        logic ack;
        logic [7:0] d;
        i2c_start;
        send_byte(RADDR, ack);
        recv_byte(1'b0, d);
        check(d == img(2), "R5 plain read follows pointer", int'(d), int'(img(2)));
        cyc(Q);
        check(sda_line == 1'b1, "R7 SDA released after NACK", int'(sda_line), 1);
        scl = 1'b1; cyc(H);
        check(sda_line == 1'b1, "R7 no drive on extra clock", int'(sda_line), 1);
        scl = 1'b0; cyc(Q);
        i2c_stop;
        check(sda_oe == 1'b0, "R7 idle after stop", int'(sda_oe), 0);
    endtask

    task automatic t_reset_reload;
        cyc(4); rst = 1'b1; cyc(4); rst = 1'b0; cyc(4);
        check(accessed == 1'b0, "R9 accessed cleared by reset", int'(accessed), 0);
        read_one("R10 R1 image restored at 0x00", img(0));
    endtask

    task automatic t_read_wrap;
        logic [7:0] d;
        set_ptr_rs(8'hFE);
        recv_byte(1'b1, d); check(d == img(254), "R5 read 0xFE", int'(d), int'(img(254)));
        recv_byte(1'b1, d); check(d == img(255), "R10 restored 0xFF", int'(d), int'(img(255)));
        recv_byte(1'b0, d); check(d == img(0), "R5 R11 read wraps to 0x00", int'(d), int'(img(0)));
        i2c_stop;
    endtask

    initial begin
        cyc(8); rst = 1'b0; cyc(8);
        t_reset_state;
        t_addr_mismatch;
        t_write_then_read;
        t_wrap_write;
        t_nack_release;
        t_reset_reload;
        t_read_wrap;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog R1-all: actual=timeout expected=completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule